// File: doc/BRIEF.md
# ModR/M Addressing Byte Parser

This block takes in the operand-addressing part of an instruction as a byte stream, one byte per valid/ready handshake. The first byte is the ModR/M byte. The block splits it into its mode, register and register-or-memory fields. From the mode and r/m values it works out whether a scale-index-base (SIB) byte follows, and whether a displacement of zero, one or four bytes follows. It then takes in those trailing bytes in order.

When the last byte has been taken, the block presents one decoded record. The record holds the register/digit field, the r/m field, a register-direct flag, a SIB-present flag with the raw SIB byte, the displacement sign-extended to 32 bits, and the total number of bytes consumed. The record stays on the output until the consumer accepts it. No new ModR/M byte is accepted in the meantime.

A decode front end uses the block after it has located the ModR/M byte. It feeds the bytes that follow and collects the record.

Top module: `modrm_parser`

## Requirements
- R1: The record reports the reg/digit field from ModR/M bits 5:3 and the r/m field from bits 2:0 of the first byte of each group.
- R2: A mode field (bits 7:6) of 11 sets the register-direct flag. No further byte is consumed, the length is 1, the displacement is 0 and the SIB flag is clear.
- R3: With a mode of 00, 01 or 10 and r/m = 100, the next byte is taken as the SIB byte. It is reported raw, the SIB flag is set, and it adds one to the length.
- R4: Mode 00 with r/m = 101 (and no SIB byte) takes a 4-byte displacement straight after the ModR/M byte, giving length 5.
- R5: Mode 01 takes one displacement byte, after the SIB byte if one is present. It is reported sign-extended to 32 bits (bit 7 copied into bits 31:8).
- R6: Mode 10 takes a 4-byte displacement, after the SIB byte if one is present. The first byte received is the least significant.
- R7: With mode 00 and a SIB byte whose base field (bits 2:0) is 101, a 4-byte little-endian displacement follows the SIB byte, giving length 6. With any other base, no displacement follows in mode 00 and the length is 2.
- R8: The record is presented with out_valid and stays unchanged until out_ready is high at a clock edge. While out_valid is high, in_ready is low.
- R9: A synchronous reset abandons any partly received group. The block returns to waiting for a ModR/M byte, with in_ready high and out_valid low.
- R10: out_len equals 1 plus 1 if a SIB byte was taken plus the number of displacement bytes, so it lies in 1..6. The displacement is 0 when none was taken.
- R11: A cycle without in_valid makes no progress: no byte is consumed and no record appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_byte holds a byte |
| in_byte | input | 8 | Next byte of the addressing group |
| in_ready | output | 1 | Block will take in_byte at this edge |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record at this edge |
| out_reg | output | 3 | reg / opcode digit field |
| out_rm | output | 3 | r/m field |
| out_direct | output | 1 | Register-direct operand (mode 11) |
| out_sib | output | 1 | A SIB byte was consumed |
| out_sib_byte | output | 8 | Raw SIB byte, 0 when absent |
| out_disp | output | 32 | Displacement, sign-extended to 32 bits |
| out_len | output | 3 | Bytes consumed, 1 to 6 |

## Verification
The assertions check on every cycle that the output handshake holds steady and excludes new input, and that reset and idle input cycles leave the block waiting. They also check that register-direct records carry length 1 with no SIB and no displacement, and that the length stays within range. Only the bench scenarios can show that each mode and r/m combination consumes the right number of bytes in the right order. They also show the little-endian assembly, the sign extension of short displacements, the SIB-base special case, and that a reset in mid-group discards what was collected.

// File: rtl/modrm_parser.sv
module modrm_parser #(
  parameter int DISP_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [7:0]              in_byte,
  output logic                    in_ready,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2:0]              out_reg,
  output logic [2:0]              out_rm,
  output logic                    out_direct,
  output logic                    out_sib,
  output logic [7:0]              out_sib_byte,
  output logic [8*DISP_BYTES-1:0] out_disp,
  output logic [2:0]              out_len
);
  localparam int DW    = 8 * DISP_BYTES;
  localparam int CNT_W = $clog2(DISP_BYTES + 1);

  typedef enum logic [1:0] {ST_MODRM, ST_SIB, ST_DISP, ST_HOLD} st_t;

  st_t              st;
  logic [1:0]       mod_q;
  logic [2:0]       reg_q, rm_q;
  logic             sib_f;
  logic [7:0]       sib_q;
  logic [DW-1:0]    disp_q;
  logic [CNT_W-1:0] need_q, got_q;
  logic [2:0]       len_q;

  logic             take;
  logic [1:0]       in_mod;
  logic [2:0]       in_rm;
  logic [CNT_W-1:0] need_m, need_s, got_nx;

  assign take   = in_valid && in_ready;
  assign in_mod = in_byte[7:6];
  assign in_rm  = in_byte[2:0];
  assign got_nx = got_q + 1'b1;

  always_comb begin
    need_m = '0;
    if (in_mod == 2'b01)                            need_m = CNT_W'(1);
    else if (in_mod == 2'b10)                       need_m = CNT_W'(DISP_BYTES);
    else if (in_mod == 2'b00 && in_rm == 3'b101)    need_m = CNT_W'(DISP_BYTES);
  end

  always_comb begin
    need_s = '0;
    if (mod_q == 2'b01)                             need_s = CNT_W'(1);
    else if (mod_q == 2'b10)                        need_s = CNT_W'(DISP_BYTES);
    else if (mod_q == 2'b00 && in_rm == 3'b101)     need_s = CNT_W'(DISP_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_MODRM;
      mod_q  <= '0;
      reg_q  <= '0;
      rm_q   <= '0;
      sib_f  <= 1'b0;
      sib_q  <= '0;
      disp_q <= '0;
      need_q <= '0;
      got_q  <= '0;
      len_q  <= '0;
    end else begin
      case (st)
        ST_MODRM: if (take) begin
          mod_q  <= in_mod;
          reg_q  <= in_byte[5:3];
          rm_q   <= in_rm;
          sib_f  <= 1'b0;
          sib_q  <= '0;
          disp_q <= '0;
          got_q  <= '0;
          need_q <= '0;
          len_q  <= 3'd1;
          if (in_mod == 2'b11) begin
            st <= ST_HOLD;
          end else if (in_rm == 3'b100) begin
            sib_f <= 1'b1;
            st    <= ST_SIB;
          end else begin
            need_q <= need_m;
            st     <= (need_m == '0) ? ST_HOLD : ST_DISP;
          end
        end
        ST_SIB: if (take) begin
          sib_q  <= in_byte;
          len_q  <= len_q + 3'd1;
          need_q <= need_s;
          st     <= (need_s == '0) ? ST_HOLD : ST_DISP;
        end
        ST_DISP: if (take) begin
          disp_q[{got_q, 3'b000} +: 8] <= in_byte;
          got_q <= got_nx;
          len_q <= len_q + 3'd1;
          if (got_nx == need_q) st <= ST_HOLD;
        end
        default: if (out_ready) st <= ST_MODRM;
      endcase
    end
  end

  assign in_ready     = (st != ST_HOLD);
  assign out_valid    = (st == ST_HOLD);
  assign out_reg      = reg_q;
  assign out_rm       = rm_q;
  assign out_direct   = (mod_q == 2'b11);
  assign out_sib      = sib_f;
  assign out_sib_byte = sib_q;
  assign out_len      = len_q;
  assign out_disp     = (need_q == CNT_W'(1)) ? {{(DW-8){disp_q[7]}}, disp_q[7:0]} : disp_q;
endmodule

module modrm_parser_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_direct,
  input logic          out_sib,
  input logic [DW-1:0] out_disp,
  input logic [2:0]    out_len
);
  // R9
  reset_state_chk: assert property (@(posedge clk) rst |=> (in_ready && !out_valid));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_disp) && $stable(out_len) && $stable(out_sib)));

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> !in_ready);

  // R2
  direct_form_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_direct) |-> (out_len == 3'd1 && !out_sib && out_disp == '0));

  // R10
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd6));

  // R3
  sib_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sib) |-> (out_len >= 3'd2));

  // R11
  idle_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid);
endmodule

bind modrm_parser modrm_parser_chk #(.DW(8 * DISP_BYTES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_direct(out_direct),
  .out_sib(out_sib), .out_disp(out_disp), .out_len(out_len)
);

// File: tb/modrm_parser_bench.sv
`timescale 1ns/1ps
module modrm_parser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_reg, out_rm, out_len;
  logic        out_direct, out_sib;
  logic [7:0]  out_sib_byte;
  logic [31:0] out_disp;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit summary_done = 0;

  always #10 clk = ~clk;

  modrm_parser u_modrm_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_reg(out_reg), .out_rm(out_rm),
    .out_direct(out_direct), .out_sib(out_sib), .out_sib_byte(out_sib_byte),
    .out_disp(out_disp), .out_len(out_len)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  function automatic bit has_sib(input logic [7:0] m);
    return (m[7:6] != 2'b11) && (m[2:0] == 3'b100);
  endfunction

  function automatic int disp_n(input logic [7:0] m, input logic [7:0] s);
    if (m[7:6] == 2'b11) return 0;
    if (m[7:6] == 2'b01) return 1;
    if (m[7:6] == 2'b10) return 4;
    if (m[2:0] == 3'b100) return (s[2:0] == 3'b101) ? 4 : 0;
    return (m[2:0] == 3'b101) ? 4 : 0;
  endfunction

  function automatic logic [31:0] exp_disp(input int n, input logic [31:0] d);
    if (n == 1) return {{24{d[7]}}, d[7:0]};
    if (n == 4) return d;
    return 32'h0;
  endfunction

  function automatic string disp_tag(input logic [7:0] m, input logic [7:0] s);
    if (m[7:6] == 2'b01) return "R5";
    if (m[7:6] == 2'b10) return "R6";
    if (m[7:6] == 2'b00 && has_sib(m)) return "R7";
    if (m[7:6] == 2'b00 && m[2:0] == 3'b101) return "R4";
    return "R10";
  endfunction

  task automatic send(input logic [7:0] b, input int gap);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk(!out_valid, "R11", "no record while input idle", {31'b0, out_valid}, 32'h0);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_txn(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d,
                         input int gap, input int hold);
    int n;
    int len;
    logic [31:0] dsave;
    logic [2:0]  lsave;
    bit got;
    string tg;
    n   = disp_n(m, s);
    len = 1 + (has_sib(m) ? 1 : 0) + n;
    tg  = disp_tag(m, s);
    send(m, gap);
    if (has_sib(m)) send(s, gap);
    for (int i = 0; i < n; i++) send(d[8*i +: 8], gap);
    got = 0;
    for (int i = 0; i < 10 && !got; i++) begin
      @(negedge clk);
      got = out_valid;
    end
    chk(got, "R10", "record appears after last byte", {31'b0, got}, 32'h1);
    if (!got) return;
    chk(out_reg == m[5:3], "R1", "reg field", {29'b0, out_reg}, {29'b0, m[5:3]});
    chk(out_rm == m[2:0], "R1", "r/m field", {29'b0, out_rm}, {29'b0, m[2:0]});
    chk(out_direct == (m[7:6] == 2'b11), "R2", "direct flag",
        {31'b0, out_direct}, {31'b0, (m[7:6] == 2'b11)});
    chk(out_sib == has_sib(m), "R3", "sib flag", {31'b0, out_sib}, {31'b0, has_sib(m)});
    chk(out_sib_byte == (has_sib(m) ? s : 8'h00), "R3", "sib byte",
        {24'b0, out_sib_byte}, {24'b0, (has_sib(m) ? s : 8'h00)});
    chk(out_disp == exp_disp(n, d), tg, "displacement", out_disp, exp_disp(n, d));
    chk(out_len == 3'(len), "R10", "length", {29'b0, out_len}, len);
    dsave = out_disp;
    lsave = out_len;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(out_valid && out_disp == dsave && out_len == lsave, "R8", "record held",
          {out_valid, 28'b0, out_len}, {1'b1, 28'b0, lsave});
      chk(!in_ready, "R8", "input blocked while record held", {31'b0, in_ready}, 32'h0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R9", "reset state", {30'b0, in_ready, out_valid}, 32'h2);
    rst = 1'b0;

    // directed corner cases
    run_txn(8'hC3, 8'h00, 32'h0, 0, 2);          // R2 register direct
    run_txn(8'h05, 8'h00, 32'h12345678, 0, 0);   // R4 disp32, no base
    run_txn(8'h45, 8'h00, 32'h00000080, 0, 1);   // R5 negative disp8
    run_txn(8'h4B, 8'h00, 32'h0000007F, 1, 0);   // R5 positive disp8
    run_txn(8'h94, 8'hA5, 32'hDEADBEEF, 0, 0);   // R6 sib + disp32
    run_txn(8'h04, 8'h25, 32'hCAFEF00D, 0, 0);   // R7 sib base 101 -> len 6
    run_txn(8'h0C, 8'h83, 32'hFFFFFFFF, 0, 0);   // R7 sib other base -> len 2
    run_txn(8'h64, 8'h11, 32'h000000F0, 2, 3);   // R5 sib then disp8

    // R11 stall mid-group
    send(8'h80, 0);
    send(8'h01, 0);
    repeat (4) begin
      @(negedge clk);
      chk(!out_valid && in_ready, "R11", "stall keeps waiting",
          {30'b0, out_valid, in_ready}, 32'h1);
    end
    send(8'h02, 0);
    send(8'h03, 0);
    send(8'h04, 0);
    @(negedge clk);
    chk(out_valid && out_disp == 32'h04030201, "R6", "little-endian after stall",
        out_disp, 32'h04030201);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;

    // R9 reset mid-group
    send(8'h84, 0);
    send(8'h00, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready && !out_valid, "R9", "reset abandons group",
        {30'b0, in_ready, out_valid}, 32'h2);
    run_txn(8'hD9, 8'h00, 32'h0, 0, 0);

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [7:0]  m, s;
      logic [31:0] d;
      m = 8'($urandom);
      s = 8'($urandom);
      d = $urandom;
      run_txn(m, s, d, int'($urandom % 3), int'($urandom % 3));
    end

    finish_run();
  end
endmodule